// File: doc/BRIEF.md
# Receiver Control Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C-compatible, fast mode) that holds the configuration bytes of a radio receiver. It presents the stored bytes to the rest of the chip as one wide parallel bus. It returns a status byte built from four live inputs: AGC engaged, antenna overcurrent, antenna load present and PLL locked. Both bus lines are brought into the system clock domain through flop synchronisers. The block finds START, STOP and clock edges there. It pulls the data line low through an open-drain enable output, and the pad ring resolves the wired-AND.

Two strap pins pick the device address. A host write sends the device address, then a register index, then any number of data bytes, which land in consecutive registers. A host read always receives a zero byte first and then the packed status. There is no streaming interface. All control and status pins are plain levels, and the block never stretches the bus clock.

Top module: `rx_ctrl_i2c_slave`

## Requirements
- R1: After reset, register bytes 0..5 hold 0x56, 0x1E, 0x90, 0x69, 0x60 and 0x04, registers 6..10 hold 0x00, and `sda_pull_o` is 0.
- R2: The 7-bit device address is {11000, sel_a, sel_b}. With sel_a/sel_b = 0/1, 1/0 and 1/1, the write address bytes are 0xC2, 0xC4 and 0xC6, and the read address bytes are 0xC3, 0xC5 and 0xC7. With both straps low, nothing is acknowledged. A non-matching address is not acknowledged, and the data bytes that follow it change no register.
- R3: Every byte moves most-significant bit first, whether received or sent.
- R4: In a write, the byte after the address byte is the register index. Each data byte after it goes to the current index, and the index then increments, until STOP.
- R5: Every byte of a write to this device is acknowledged, including data bytes aimed at indices with no register.
- R6: A data byte written to index 11 or above changes no register.
- R7: A read returns 0x00 and then the status byte {0000, agc, overcurrent, antenna_present, pll_locked}, with pll_locked in bit 0.
- R8: The status value is captured on the SCL falling edge that ends the acknowledge of the zero byte. Status changes after that edge do not alter the byte being sent.
- R9: A START or STOP in the middle of a byte abandons that byte. A partial data byte is never written.
- R10: After STOP, and after the host NACKs a read byte, `sda_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| sel_a | input | 1 | Address strap, bit 1 of the address select |
| sel_b | input | 1 | Address strap, bit 0 of the address select |
| agc_active_i | input | 1 | RF gain loop engaged |
| ant_overcur_i | input | 1 | Antenna supply overcurrent |
| ant_present_i | input | 1 | Antenna load current detected |
| pll_locked_i | input | 1 | Synthesiser locked |
| cfg_o | output | 88 | Register bytes, register k at bits [8k+7:8k] |

## Verification
Two situations can land in the same cycle. The first is a change of a live status input at the moment the status value is captured. The second is a START or STOP arriving while a byte is still half shifted in. The bench changes the status inputs just before the acknowledge of the zero byte and again just after it. It expects the value present at the acknowledge's falling edge. It also breaks off data bytes after a few bits with a repeated START or a STOP, and then checks that the target register keeps its old value while the next full transfer still works.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDAT, ST_ACK, ST_TX, ST_RACK
  } xfer_st_e;

  function automatic logic [7:0] rst_byte(input int idx);
    case (idx)
      0:       return 8'h56;
      1:       return 8'h1E;
      2:       return 8'h90;
      3:       return 8'h69;
      4:       return 8'h60;
      5:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rxc_line_sync.sv
module rxc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/rxc_xfer_fsm.sv
module rxc_xfer_fsm
  import rxc_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_ok,
  input  logic [6:0]        dev_addr,
  input  logic [STAT_W-1:0] status,
  output logic              wr_en,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              sda_pull,
  output xfer_st_e          st_o
);
  xfer_st_e   st, after_ack;
  logic [7:0] sr, ptr;
  logic [2:0] cnt;
  logic       full, tx_idx, m_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; after_ack <= ST_IDLE;
      sr <= '0; ptr <= '0; cnt <= '0;
      full <= 1'b0; tx_idx <= 1'b0; m_ack <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; full <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; full <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG, ST_WDAT: begin
            if (scl_rise && !full) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end
            if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              if (st == ST_ADDR) begin
                if (addr_ok && sr[7:1] == dev_addr) begin
                  st        <= ST_ACK;
                  after_ack <= sr[0] ? ST_TX : ST_REG;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_REG) begin
                ptr <= sr; st <= ST_ACK; after_ack <= ST_WDAT;
              end else begin
                wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sr;
                ptr <= ptr + 8'd1; st <= ST_ACK; after_ack <= ST_WDAT;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            st <= after_ack;
            if (after_ack == ST_TX) begin
              sr <= 8'h00; cnt <= '0; tx_idx <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            sr  <= {sr[6:0], 1'b0};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= ST_RACK;
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                st     <= ST_TX;
                cnt    <= '0;
                sr     <= tx_idx ? 8'h00 : 8'({status});
                tx_idx <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = (st == ST_ACK) || (st == ST_TX && !sr[7]);
  assign st_o     = st;
endmodule

// File: rtl/rxc_regfile.sv
module rxc_regfile
  import rxc_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] IDX = 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= rst_byte(g);
      else if (wr_en && wr_addr == IDX)  q <= wr_data;
    end
    assign cfg_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/rx_ctrl_i2c_slave.sv
module rx_ctrl_i2c_slave
  import rxc_pkg::*;
#(
  parameter int NUM_REGS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic                  sel_a,
  input  logic                  sel_b,
  input  logic                  agc_active_i,
  input  logic                  ant_overcur_i,
  input  logic                  ant_present_i,
  input  logic                  pll_locked_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int STAT_W = 4;

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [6:0] dev_addr;
  logic       addr_ok;
  xfer_st_e   xfer_st;
  logic [STAT_W-1:0] status;

  assign dev_addr = {5'b11000, sel_a, sel_b};
  assign addr_ok  = sel_a | sel_b;
  assign status   = {agc_active_i, ant_overcur_i, ant_present_i, pll_locked_i};

  rxc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rxc_xfer_fsm #(.STAT_W(STAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_ok(addr_ok), .dev_addr(dev_addr), .status(status),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .st_o(xfer_st)
  );

  rxc_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/rxc_i2c_chk.sv
module rxc_i2c_chk
  import rxc_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_pull,
  input logic [NUM_REGS*8-1:0] cfg,
  input logic                  wr_en,
  input logic [7:0]            wr_addr,
  input logic                  start_det,
  input logic                  stop_det,
  input xfer_st_e              st
);
  localparam logic [7:0] LIMIT = 8'(NUM_REGS);

  // R5
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_pull);

  // R6
  oor_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= LIMIT) |=> $stable(cfg));

  // R9
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

bind rx_ctrl_i2c_slave rxc_i2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .cfg(cfg_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .start_det(start_det),
  .stop_det(stop_det), .st(xfer_st)
);

// File: tb/rx_ctrl_i2c_slave_bench.sv
module rx_ctrl_i2c_slave_bench;
  localparam int NR = 11;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sel_a = 1'b1, sel_b = 1'b1;
  logic [3:0] stat = 4'h0;
  logic sda_pull;
  logic [NR*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NR];
  logic [7:0] wbuf [16];

  always #2 clk = ~clk;

  rx_ctrl_i2c_slave u_rx_ctrl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .sel_a(sel_a), .sel_b(sel_b),
    .agc_active_i(stat[3]), .ant_overcur_i(stat[2]),
    .ant_present_i(stat[1]), .pll_locked_i(stat[0]), .cfg_o(cfg)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_bits(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
  endtask

  // write n bytes from wbuf to register index ridx, model updated
  task automatic wr_txn(logic [7:0] dev, logic [7:0] ridx, int n, string tag);
    logic ack;
    bus_start();
    send_byte(dev, ack);   check({tag, " addr ack R5"}, ack, 1);
    send_byte(ridx, ack);  check({tag, " index ack R5"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      check({tag, " data ack R5"}, ack, 1);
      if (int'(ridx) + k < NR) model[int'(ridx) + k] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic cmp_regs(string tag);
    for (int k = 0; k < NR; k++) check(tag, cfg[k*8 +: 8], model[k]);
  endtask

  function automatic logic [7:0] rst_val(int k);
    logic [7:0] t [6] = '{8'h56, 8'h1E, 8'h90, 8'h69, 8'h60, 8'h04};
    return (k < 6) ? t[k] : 8'h00;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack, bb;
    logic [7:0] rv;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R1: reset contents and released data line
    for (int k = 0; k < NR; k++) model[k] = rst_val(k);
    check("R1 sda released", sda_pull, 0);
    cmp_regs("R1 reset byte");

    // R4 R3 R6: one burst over every register and two indices past the end
    for (int k = 0; k < NR + 2; k++) wbuf[k] = 8'((k * 37 + 5) ^ (k << 5));
    wr_txn(8'hC6, 8'h00, NR + 2, "burst");
    cmp_regs("R4 R3 burst write");

    // R4: burst from the middle
    for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'hA1 + k * 16);
    wr_txn(8'hC6, 8'h05, 3, "mid");
    cmp_regs("R4 mid burst");

    // R6: start index beyond the map
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    wr_txn(8'hC6, 8'h20, 2, "oor");
    cmp_regs("R6 out of range ignored");

    // R2: strap and address sweep
    for (int s = 0; s < 4; s++) begin
      {sel_a, sel_b} = 2'(s);
      for (int a = 8'h60; a < 8'h68; a++) begin
        bus_start();
        send_byte(8'({a[6:0], 1'b0}), ack);
        bus_stop();
        check("R2 address ack", ack, (s != 0 && a == (8'h60 | s)) ? 1 : 0);
      end
    end
    // R2: mismatched address followed by index and data
    {sel_a, sel_b} = 2'b10;
    bus_start();
    send_byte(8'hC6, ack); check("R2 mismatch no ack", ack, 0);
    send_byte(8'h01, ack); send_byte(8'h00, ack);
    bus_stop();
    cmp_regs("R2 mismatch no write");
    wbuf[0] = 8'h5A;
    wr_txn(8'hC4, 8'h01, 1, "strap10");
    cmp_regs("R2 strap 1/0 write");
    {sel_a, sel_b} = 2'b11;

    // R7 R3: every status pattern, MSB first
    for (int v = 0; v < 16; v++) begin
      stat = 4'(v);
      bus_start();
      send_byte(8'hC7, ack); check("R7 read addr ack", ack, 1);
      recv_bits(rv); send_bit(1'b0);
      check("R7 reserved byte", rv, 8'h00);
      recv_bits(rv); send_bit(1'b1);
      check("R7 R3 status byte", rv, 8'(v));
      check("R10 release after nack", sda_pull, 0);
      bus_stop();
    end

    // R8: status moves just before and just after the capture edge
    stat = 4'h5;
    bus_start();
    send_byte(8'hC7, ack);
    recv_bits(rv);
    stat = 4'h3;
    send_bit(1'b0);
    stat = 4'hC;
    recv_bits(rv); send_bit(1'b1);
    bus_stop();
    check("R8 status captured at ack", rv, 8'h03);
    check("R10 released after stop", sda_pull, 0);

    // R9: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'hC6, ack); send_byte(8'h02, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    wbuf[0] = 8'h77;
    wr_txn(8'hC6, 8'h03, 1, "after restart");
    cmp_regs("R9 restart abort");

    // R9: STOP in the middle of a data byte
    bus_start();
    send_byte(8'hC6, ack); send_byte(8'h04, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    cmp_regs("R9 stop abort");
    bus_start();
    send_byte(8'hC7, ack); check("R9 bus usable after abort", ack, 1);
    recv_bit(bb); recv_bits(rv); send_bit(1'b1);
    bus_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule